// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a CPU core and decides which pending request the core should service next. Five exception inputs sit at the top of the order: three reset causes and two traps. These are level requests. The core's global interrupt mask and the local enables cannot block them. The remaining sources are ordinary interrupts. Each one has one or more causes. A cause is latched as a flag when its hardware event pulses, and it stays latched until software clears it with a write-one-to-clear strobe.

An ordinary source requests service when at least one of its causes has both its flag and its enable set, and the global mask input is low. Among all requesting sources, the lowest index wins. The block registers the request line and the winning index. From the registered index it forms the address of that source's two-byte vector slot in a table at the top of a 16-bit memory map. The core reads the handler address from that slot.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `vec_o` equals 0xFFFE minus twice `src_o`, so every slot address lies between 0xFF00 and 0xFFFF.
- R2: When several sources request at once, the lowest index is reported in `src_o`.
- R3: Sources 0 to 2 (resets) and 3 to 4 (traps) are driven by `exc_i[0..4]`. They request whenever their input is high, whatever the state of `mask_i` and `en_i`.
- R4: An ordinary source never requests while `mask_i` is high. It also never requests while none of its causes has both its flag and its enable set.
- R5: An event pulse sets its cause flag. The flag holds until a clear strobe arrives for that bit. If an event and a clear arrive in the same cycle, the flag ends up set.
- R6: Ordinary source index 5+j owns the cause bits j*N_CAUSE+c, for c from 0 to N_CAUSE-1. Its causes are ORed into one request.
- R7: `irq_o` and `src_o` are registered. They reflect the flags, enables, mask and exception inputs present at the previous clock edge. When nothing requests, `irq_o` is 0 and `src_o` is 0.
- R8: A synchronous active-low reset clears all flags and sets `irq_o` to 0 and `src_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | (N_SRC-5)*N_CAUSE | Event pulses, one per cause |
| en_i | input | (N_SRC-5)*N_CAUSE | Local enables, one per cause |
| clr_i | input | (N_SRC-5)*N_CAUSE | Write-one-to-clear strobes, one per cause |
| mask_i | input | 1 | Global mask for ordinary interrupts |
| exc_i | input | 5 | Reset (bits 0-2) and trap (bits 3-4) requests |
| flags_o | output | (N_SRC-5)*N_CAUSE | Latched cause flags |
| irq_o | output | 1 | Registered service request |
| src_o | output | $clog2(N_SRC) | Registered winning source index |
| vec_o | output | 16 | Vector slot address of the winner |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any input activity is judged. They also assume that all inputs are stable around the clock edge. The bench drives every input on the falling edge and releases reset only after several cycles. It keeps exception requests rare, so that the ordinary sources, their masking and their priority are exercised too. Event and clear strobes are drawn sparsely and at random. Directed cases are added for the situations random draws seldom produce: a set and a clear on the same bit in the same cycle, and a cause enabled while the mask is set.

// File: rtl/ivc_pkg.sv
// Package: fixed tier sizes and vector table geometry shared by the controller.
// Assumes a 16-bit address map with the table ending at the top of memory.
package ivc_pkg;
    localparam int N_RESET   = 3;
    localparam int N_TRAP    = 2;
    localparam int N_EXC     = N_RESET + N_TRAP;
    localparam int ADDR_W    = 16;
    localparam logic [ADDR_W-1:0] VEC_TOP = 16'hFFFE;
    localparam logic [ADDR_W-1:0] VEC_LOW = 16'hFF00;
endpackage

// File: rtl/ivc_flag_bank.sv
// Module: one latched flag per interrupt cause.
// An event pulse sets the flag and a clear strobe drops it; set has priority.
// Assumes event and clear inputs are synchronous to clk.
module ivc_flag_bank #(
    parameter int N_BIT = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BIT-1:0] evt_i,
    input  logic [N_BIT-1:0] clr_i,
    output logic [N_BIT-1:0] flag_o
);
    for (genvar k = 0; k < N_BIT; k++) begin : g_flag
        logic flag_q;

        // Hold, clear or set one cause flag.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (evt_i[k])   flag_q <= 1'b1;
            else if (clr_i[k])   flag_q <= 1'b0;
        end

        assign flag_o[k] = flag_q;

        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> flag_o[k]);
        a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !evt_i[k]) |=> !flag_o[k]);
        a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[k] && !clr_i[k]) |=> flag_o[k]);
    end
endmodule

// File: rtl/ivc_cause_merge.sv
// Module: folds the enabled cause flags of each ordinary source into one request.
// Assumes cause bits are grouped per source, N_CAUSE consecutive bits each.
module ivc_cause_merge #(
    parameter int N_ORD   = 11,
    parameter int N_CAUSE = 2
) (
    input  logic [N_ORD*N_CAUSE-1:0] flag_i,
    input  logic [N_ORD*N_CAUSE-1:0] en_i,
    output logic [N_ORD-1:0]         req_o
);
    for (genvar j = 0; j < N_ORD; j++) begin : g_src
        assign req_o[j] = |(flag_i[j*N_CAUSE +: N_CAUSE] & en_i[j*N_CAUSE +: N_CAUSE]);
    end
endmodule

// File: rtl/ivc_prio_enc.sv
// Module: fixed-priority encoder; the lowest requesting index wins.
// Returns index 0 and any_o low when nothing requests.
module ivc_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from lowest priority upward so the lowest set index remains.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: prioritized interrupt vector controller (top).
// Sources 0..4 are unmaskable resets and traps taken from exc_i; the rest are
// ordinary interrupts with latched, enabled causes gated by mask_i.
// The request and winner are registered; vec_o is derived from the winner.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int N_SRC   = 16,
    parameter int N_CAUSE = 2,
    localparam int N_ORD  = N_SRC - N_EXC,
    localparam int N_BIT  = N_ORD * N_CAUSE,
    localparam int IDX_W  = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BIT-1:0]  evt_i,
    input  logic [N_BIT-1:0]  en_i,
    input  logic [N_BIT-1:0]  clr_i,
    input  logic              mask_i,
    input  logic [N_EXC-1:0]  exc_i,
    output logic [N_BIT-1:0]  flags_o,
    output logic              irq_o,
    output logic [IDX_W-1:0]  src_o,
    output logic [ADDR_W-1:0] vec_o
);
    logic [N_ORD-1:0] ord_req;
    logic [N_SRC-1:0] all_req;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic             irq_q;
    logic [IDX_W-1:0] src_q;

    ivc_flag_bank #(.N_BIT(N_BIT)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_i), .flag_o(flags_o)
    );

    ivc_cause_merge #(.N_ORD(N_ORD), .N_CAUSE(N_CAUSE)) u_merge (
        .flag_i(flags_o), .en_i(en_i), .req_o(ord_req)
    );

    // Exceptions bypass the mask; ordinary requests are gated by it.
    assign all_req = {ord_req & {N_ORD{~mask_i}}, exc_i};

    ivc_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_enc (
        .req_i(all_req), .any_o(any_req), .idx_o(win_idx)
    );

    // Register the request line and the winning index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            src_q <= '0;
        end else begin
            irq_q <= any_req;
            src_q <= win_idx;
        end
    end

    assign irq_o = irq_q;
    assign src_o = src_q;
    assign vec_o = VEC_TOP - (ADDR_W'(src_q) << 1);

    a_r3_exc_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (|exc_i) |=> irq_o);
    a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i[0] |=> (src_o == '0));
    a_r4_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !(|exc_i)) |=> !irq_o);
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (src_o == '0));
    a_r1_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o >= VEC_LOW);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    localparam int PERIOD  = 10;
    localparam int N_SRC   = 16;
    localparam int N_CAUSE = 2;
    localparam int N_EXC   = 5;
    localparam int N_ORD   = N_SRC - N_EXC;
    localparam int NB      = N_ORD * N_CAUSE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0] evt = '0, en = '0, clr = '0;
    logic mask = 1'b0;
    logic [N_EXC-1:0] exc = '0;
    logic [NB-1:0] flags;
    logic irq;
    logic [3:0] src;
    logic [15:0] vec;

    int errors = 0, checks = 0;
    logic [NB-1:0] m_flags = '0;
    logic m_irq = 1'b0;
    logic [3:0] m_src = '0;

    always #(PERIOD/2) clk = ~clk;

    irq_vector_ctrl #(.N_SRC(N_SRC), .N_CAUSE(N_CAUSE)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .clr_i(clr),
        .mask_i(mask), .exc_i(exc), .flags_o(flags), .irq_o(irq),
        .src_o(src), .vec_o(vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected winner from the requirements: exceptions, then enabled causes when unmasked.
    function automatic logic [4:0] pick(input logic [NB-1:0] f, input logic [NB-1:0] e,
                                        input logic m, input logic [N_EXC-1:0] x);
        for (int s = 0; s < N_SRC; s++) begin
            if (s < N_EXC) begin
                if (x[s]) return {1'b1, 4'(s)};
            end else if (!m && |(f[(s-N_EXC)*N_CAUSE +: N_CAUSE] & e[(s-N_EXC)*N_CAUSE +: N_CAUSE])) begin
                return {1'b1, 4'(s)};
            end
        end
        return 5'b0;
    endfunction

    task automatic step(input logic [NB-1:0] ev, input logic [NB-1:0] ne,
                        input logic [NB-1:0] cl, input logic mk, input logic [N_EXC-1:0] ex);
        logic [4:0] p;
        @(negedge clk);
        evt = ev; en = ne; clr = cl; mask = mk; exc = ex;
        p = pick(m_flags, ne, mk, ex);
        m_irq = p[4];
        m_src = p[3:0];
        m_flags = (m_flags & ~cl) | ev;
        @(posedge clk);
        #1;
        check("R5 flags", 32'(flags), 32'(m_flags));
        check("R7 irq", 32'(irq), 32'(m_irq));
        check("R2 src", 32'(src), 32'(m_src));
        check("R1 vec", 32'(vec), 32'(16'hFFFE - 16'(m_src) * 2));
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset flags", 32'(flags), 0);
        check("R8 reset irq", 32'(irq), 0);
        check("R8 reset src", 32'(src), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: event latches first, request follows one edge later.
        step(NB'(1) << 4, NB'(1) << 4, '0, 1'b0, '0);
        check("R7 one-cycle latency", 32'(irq), 0);
        step('0, NB'(1) << 4, '0, 1'b0, '0);
        check("R7 request after flag", 32'(irq), 1);
        check("R6 cause 0 of ordinary 2", 32'(src), 7);

        // R5: set and clear in the same cycle leave the flag set.
        step(NB'(1) << 4, NB'(1) << 4, NB'(1) << 4, 1'b0, '0);
        check("R5 set wins", 32'(flags[4]), 1);

        // R4: masked ordinary requests stay quiet.
        step('0, NB'(1) << 4, '0, 1'b1, '0);
        check("R4 masked", 32'(irq), 0);

        // R3: a trap is taken while masked and with no enables.
        step('0, '0, '0, 1'b1, 5'b10000);
        check("R3 trap unmaskable", 32'(src), 4);
        check("R3 trap vector", 32'(vec), 32'hFFF6);

        // R6: second cause of ordinary source 0 alone reaches source index 5.
        step(NB'(2), NB'(2), NB'(1) << 4, 1'b0, '0);
        step('0, NB'(2), '0, 1'b0, '0);
        check("R6 cause 1 of ordinary 0", 32'(src), 5);

        // R1: lowest ordinary source maps to slot address 0xFFF4.
        check("R1 vec ordinary 0", 32'(vec), 32'hFFF4);

        for (int i = 0; i < 3000; i++) begin
            logic [NB-1:0] ev, cl;
            logic [N_EXC-1:0] ex;
            ev = NB'($urandom) & NB'($urandom) & NB'($urandom);
            cl = NB'($urandom) & NB'($urandom);
            ex = '0;
            for (int b = 0; b < N_EXC; b++) ex[b] = ($urandom % 24) == 0;
            step(ev, NB'($urandom), cl, ($urandom % 4) == 0, ex);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule